// File: doc/BRIEF.md
# Pipelined Control Decode and Staging

This block turns the opcode held in the decode stage into the nine control bits a five-stage datapath needs, then carries them forward through three control pipeline registers. Each bit group leaves the pipeline at the stage that uses it. The execute stage receives destination-select, operand-select and the two-bit ALU class. The memory stage receives branch, read and write. Writeback receives result-select and register-write. No control bit is consumed in decode itself.

Three requests can interrupt the normal flow, and each clears a different depth of the pipeline:
- A load-use **stall** puts a bubble into the decode/execute register.
- A **taken branch** also bubbles that register, flushes the fetched instruction and steers the PC to the branch target.
- An ALU **overflow** seen in execute flushes fetch, decode and execute. It clears the control entering both the decode/execute and execute/memory registers, so the faulting result never reaches writeback. It also steers the PC to a fixed exception vector.

The block holds only control state. The ALU, register file and memories sit outside it.

Top module: `pipe_ctrl`

## Requirements
- R1: Opcode 0x00 (register-register) decodes to regDst=1, aluSrc=0, aluOp=2'b10, regWrite=1, and every other bit 0. The ALU class is never 2'b11.
- R2: Opcode 0x23 (load word) decodes to aluSrc=1, aluOp=2'b00, memRead=1, memToReg=1, regWrite=1, and every other bit 0.
- R3: Opcode 0x2B (store word) decodes to aluSrc=1, aluOp=2'b00, memWrite=1, and every other bit 0.
- R4: Opcode 0x04 (branch-on-equal) decodes to aluOp=2'b01, branch=1, and every other bit 0. A memory-stage branch is never accompanied by a memory read or write.
- R5: Any other opcode decodes to all nine bits 0.
- R6: For an opcode presented before clock edge k, the execute group is visible after edge k, the memory group after edge k+1 and the writeback group after edge k+2.
- R7: A stall makes the execute group 0 after the next edge. Older stages advance unchanged, all three flush strobes stay 0 and pcSel stays 2'b00.
- R8: A taken branch raises ifFlush and idFlush in the same cycle, leaves exFlush at 0 and sets pcSel=2'b01. It makes the execute group 0 after the next edge while the memory stage still advances.
- R9: An overflow raises ifFlush, idFlush and exFlush and sets pcSel=2'b10. It makes both the execute group and the memory group 0 after the next edge, so that instruction's writeback bits end up 0.
- R10: The pcSel priority is overflow (2'b10) over taken branch (2'b01) over sequential (2'b00).
- R11: A synchronous active-high reset clears all three control registers to 0.
- R12: excTarget always equals the exception vector parameter, which defaults to 0x80000180.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode of the instruction in decode |
| stall | input | 1 | Load-use bubble request |
| branchTaken | input | 1 | Taken-branch flush request |
| overflow | input | 1 | ALU overflow exception request |
| exRegDst | output | 1 | Execute: destination register select |
| exAluSrc | output | 1 | Execute: immediate operand select |
| exAluOp | output | 2 | Execute: ALU class |
| memBranch | output | 1 | Memory: branch instruction |
| memRead | output | 1 | Memory: data read enable |
| memWrite | output | 1 | Memory: data write enable |
| wbMemToReg | output | 1 | Writeback: select memory data |
| wbRegWrite | output | 1 | Writeback: register write enable |
| ifFlush | output | 1 | Clear the fetch/decode instruction register |
| idFlush | output | 1 | Clear control entering decode/execute |
| exFlush | output | 1 | Clear control entering execute/memory |
| pcSel | output | 2 | PC source: 00 sequential, 01 branch, 10 exception |
| excTarget | output | 32 | Exception vector address |

## Verification
A taken branch and an overflow can arrive in the same cycle. A stall can also coincide with either of them. The bench drives these pairs together while a load and a store are still in flight in older stages. Each coincidence is judged on three things: pcSel must follow the overflow-first priority, the strobe set must be the union of both requests, and the depth of cleared stages must match the deeper request. A behavioural model tracks every in-flight instruction and checks that stages behind the cleared ones keep advancing.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;

  typedef struct packed {
    logic       regDst;
    logic       aluSrc;
    logic [1:0] aluOp;
  } exCtrl_t;

  typedef struct packed {
    logic branch;
    logic memRead;
    logic memWrite;
  } memCtrl_t;

  typedef struct packed {
    logic memToReg;
    logic regWrite;
  } wbCtrl_t;

  typedef struct packed {
    exCtrl_t  ex;
    memCtrl_t mem;
    wbCtrl_t  wb;
  } ctrlBundle_t;

  typedef enum logic [1:0] {
    PC_SEQ    = 2'b00,
    PC_BRANCH = 2'b01,
    PC_EXC    = 2'b10
  } pcSel_e;

  typedef struct packed {
    logic   bubbleId;
    logic   flushIf;
    logic   flushId;
    logic   flushEx;
    pcSel_e pcSel;
  } strobe_t;
endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import ctrl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctrlBundle_t     bundle
);
  always_comb begin
    bundle = '0;
    unique case (opcode)
      OP_RTYPE: begin
        bundle.ex.regDst   = 1'b1;
        bundle.ex.aluOp    = 2'b10;
        bundle.wb.regWrite = 1'b1;
      end
      OP_LOAD: begin
        bundle.ex.aluSrc    = 1'b1;
        bundle.mem.memRead  = 1'b1;
        bundle.wb.memToReg  = 1'b1;
        bundle.wb.regWrite  = 1'b1;
      end
      OP_STORE: begin
        bundle.ex.aluSrc    = 1'b1;
        bundle.mem.memWrite = 1'b1;
      end
      OP_BEQ: begin
        bundle.ex.aluOp     = 2'b01;
        bundle.mem.branch   = 1'b1;
      end
      default: bundle = '0;
    endcase
  end
endmodule

// File: rtl/ctrl_hazard.sv
module ctrl_hazard
  import ctrl_pkg::*;
(
  input  logic    stall,
  input  logic    branchTaken,
  input  logic    overflow,
  output strobe_t strobe
);
  always_comb begin
    strobe.bubbleId = stall;
    strobe.flushIf  = branchTaken | overflow;
    strobe.flushId  = branchTaken | overflow;
    strobe.flushEx  = overflow;
    if (overflow)         strobe.pcSel = PC_EXC;
    else if (branchTaken) strobe.pcSel = PC_BRANCH;
    else                  strobe.pcSel = PC_SEQ;
  end
endmodule

// File: rtl/ctrl_stage_regs.sv
module ctrl_stage_regs
  import ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ctrlBundle_t decoded,
  input  strobe_t     strobe,
  output exCtrl_t     exOut,
  output memCtrl_t    memOut,
  output wbCtrl_t     wbOut
);
  ctrlBundle_t idEx;
  memCtrl_t    exMemM;
  wbCtrl_t     exMemW;
  wbCtrl_t     memWb;

  always_ff @(posedge clk) begin
    if (rst || strobe.bubbleId || strobe.flushId) idEx <= '0;
    else                                          idEx <= decoded;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.flushEx) begin
      exMemM <= '0;
      exMemW <= '0;
    end else begin
      exMemM <= idEx.mem;
      exMemW <= idEx.wb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) memWb <= '0;
    else     memWb <= exMemW;
  end

  assign exOut  = idEx.ex;
  assign memOut = exMemM;
  assign wbOut  = memWb;
endmodule

// File: rtl/pipe_ctrl.sv
module pipe_ctrl
  import ctrl_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter logic [PC_W-1:0] EXC_VECTOR = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            stall,
  input  logic            branchTaken,
  input  logic            overflow,
  output logic            exRegDst,
  output logic            exAluSrc,
  output logic [1:0]      exAluOp,
  output logic            memBranch,
  output logic            memRead,
  output logic            memWrite,
  output logic            wbMemToReg,
  output logic            wbRegWrite,
  output logic            ifFlush,
  output logic            idFlush,
  output logic            exFlush,
  output logic [1:0]      pcSel,
  output logic [PC_W-1:0] excTarget
);
  ctrlBundle_t decoded;
  strobe_t     strobe;
  exCtrl_t     exOut;
  memCtrl_t    memOut;
  wbCtrl_t     wbOut;

  ctrl_decode dec_i (.opcode(opcode), .bundle(decoded));

  ctrl_hazard haz_i (
    .stall(stall), .branchTaken(branchTaken), .overflow(overflow), .strobe(strobe)
  );

  ctrl_stage_regs regs_i (
    .clk(clk), .rst(rst), .decoded(decoded), .strobe(strobe),
    .exOut(exOut), .memOut(memOut), .wbOut(wbOut)
  );

  assign exRegDst   = exOut.regDst;
  assign exAluSrc   = exOut.aluSrc;
  assign exAluOp    = exOut.aluOp;
  assign memBranch  = memOut.branch;
  assign memRead    = memOut.memRead;
  assign memWrite   = memOut.memWrite;
  assign wbMemToReg = wbOut.memToReg;
  assign wbRegWrite = wbOut.regWrite;
  assign ifFlush    = strobe.flushIf;
  assign idFlush    = strobe.flushId;
  assign exFlush    = strobe.flushEx;
  assign pcSel      = strobe.pcSel;
  assign excTarget  = EXC_VECTOR;
endmodule

// File: rtl/pipe_ctrl_chk.sv
module pipe_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       stall,
  input logic       branchTaken,
  input logic       overflow,
  input logic       exRegDst,
  input logic       exAluSrc,
  input logic [1:0] exAluOp,
  input logic       memBranch,
  input logic       memRead,
  input logic       memWrite,
  input logic       wbMemToReg,
  input logic       wbRegWrite,
  input logic       ifFlush,
  input logic       idFlush,
  input logic       exFlush,
  input logic [1:0] pcSel
);
  assert_aluop_legal_R1: assert property (@(posedge clk) disable iff (rst)
    exAluOp != 2'b11);

  assert_load_reaches_wb_R2: assert property (@(posedge clk) disable iff (rst)
    memRead |=> (wbMemToReg && wbRegWrite));

  assert_branch_alone_R4: assert property (@(posedge clk) disable iff (rst)
    memBranch |-> (!memRead && !memWrite));

  assert_bubble_ex_R7: assert property (@(posedge clk) disable iff (rst)
    (stall || branchTaken || overflow) |=> (!exRegDst && !exAluSrc && exAluOp == 2'b00));

  assert_stall_no_flush_R7: assert property (@(posedge clk) disable iff (rst)
    (stall && !branchTaken && !overflow) |-> (!ifFlush && !idFlush && !exFlush && pcSel == 2'b00));

  assert_branch_strobes_R8: assert property (@(posedge clk) disable iff (rst)
    (branchTaken && !overflow) |-> (ifFlush && idFlush && !exFlush));

  assert_exc_clears_mem_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> (!memBranch && !memRead && !memWrite));

  assert_exc_strobes_R9: assert property (@(posedge clk) disable iff (rst)
    exFlush |-> (ifFlush && idFlush));

  assert_pc_priority_R10: assert property (@(posedge clk) disable iff (rst)
    overflow |-> pcSel == 2'b10);

  assert_pc_branch_R10: assert property (@(posedge clk) disable iff (rst)
    (branchTaken && !overflow) |-> pcSel == 2'b01);

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!exRegDst && !exAluSrc && !memRead && !memWrite && !memBranch));
endmodule

bind pipe_ctrl pipe_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .stall(stall), .branchTaken(branchTaken), .overflow(overflow),
  .exRegDst(exRegDst), .exAluSrc(exAluSrc), .exAluOp(exAluOp),
  .memBranch(memBranch), .memRead(memRead), .memWrite(memWrite),
  .wbMemToReg(wbMemToReg), .wbRegWrite(wbRegWrite),
  .ifFlush(ifFlush), .idFlush(idFlush), .exFlush(exFlush), .pcSel(pcSel)
);

// File: tb/pipe_ctrl_tb_top.sv
module pipe_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = 6'h00;
  logic        stall = 1'b0, branchTaken = 1'b0, overflow = 1'b0;
  logic        exRegDst, exAluSrc, memBranch, memRead, memWrite, wbMemToReg, wbRegWrite;
  logic [1:0]  exAluOp, pcSel;
  logic        ifFlush, idFlush, exFlush;
  logic [31:0] excTarget;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model order: regDst aluSrc aluOp[1:0] branch memRead memWrite memToReg regWrite
  logic [8:0] mIdEx = '0, mExMem = '0, mMemWb = '0;

  always #5 clk = ~clk;

  pipe_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .stall(stall), .branchTaken(branchTaken),
    .overflow(overflow), .exRegDst(exRegDst), .exAluSrc(exAluSrc), .exAluOp(exAluOp),
    .memBranch(memBranch), .memRead(memRead), .memWrite(memWrite),
    .wbMemToReg(wbMemToReg), .wbRegWrite(wbRegWrite), .ifFlush(ifFlush),
    .idFlush(idFlush), .exFlush(exFlush), .pcSel(pcSel), .excTarget(excTarget)
  );

  function automatic logic [8:0] expDecode(input logic [5:0] op);
    case (op)
      6'h00:   return 9'b1_0_10_000_01;
      6'h23:   return 9'b0_1_00_010_11;
      6'h2B:   return 9'b0_1_00_001_00;
      6'h04:   return 9'b0_0_01_100_00;
      default: return 9'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [5:0] op, input logic st,
                      input logic br, input logic ov, input string tag);
    logic [1:0] expSel;
    @(negedge clk);
    rst = r; opcode = op; stall = st; branchTaken = br; overflow = ov;
    #1;
    expSel = ov ? 2'b10 : (br ? 2'b01 : 2'b00);
    check(tag, "strobes", {29'b0, ifFlush, idFlush, exFlush}, {29'b0, br | ov, br | ov, ov});
    check(tag, "pcSel", {30'b0, pcSel}, {30'b0, expSel});
    check(tag, "exGroup", {28'b0, exRegDst, exAluSrc, exAluOp}, {28'b0, mIdEx[8:5]});
    check(tag, "memGroup", {29'b0, memBranch, memRead, memWrite}, {29'b0, mExMem[4:2]});
    check(tag, "wbGroup", {30'b0, wbMemToReg, wbRegWrite}, {30'b0, mMemWb[1:0]});
    if (r) begin
      mMemWb = '0; mExMem = '0; mIdEx = '0;
    end else begin
      mMemWb = {7'b0, mExMem[1:0]};
      mExMem = ov ? 9'b0 : {4'b0, mIdEx[4:0]};
      mIdEx  = (st | br | ov) ? 9'b0 : expDecode(op);
    end
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3; i++) step(1'b0, 6'h3F, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R11: state after power-on reset
    step(1'b0, 6'h3F, 1'b0, 1'b0, 1'b0, "R11");
    // R1 register-register stream
    for (int i = 0; i < 3; i++) step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, "R1");
    drain("R1");
    // R2 load
    step(1'b0, 6'h23, 1'b0, 1'b0, 1'b0, "R2");
    drain("R2");
    // R3 store
    step(1'b0, 6'h2B, 1'b0, 1'b0, 1'b0, "R3");
    drain("R3");
    // R4 branch-on-equal
    step(1'b0, 6'h04, 1'b0, 1'b0, 1'b0, "R4");
    drain("R4");
    // R5 unknown opcodes after a live instruction
    step(1'b0, 6'h23, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 6'h08, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 6'h3F, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 6'h22, 1'b0, 1'b0, 1'b0, "R5");
    drain("R5");
    // R6 mixed back-to-back stream
    step(1'b0, 6'h23, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 6'h2B, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 6'h04, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 6'h23, 1'b0, 1'b0, 1'b0, "R6");
    drain("R6");
    // R7 stall behind a load
    step(1'b0, 6'h23, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 6'h00, 1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, "R7");
    drain("R7");
    // R8 taken branch while load in flight
    step(1'b0, 6'h23, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 6'h2B, 1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, "R8");
    drain("R8");
    // R9 overflow kills load in execute and its writeback
    step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b0, 6'h23, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b0, 6'h2B, 1'b0, 1'b0, 1'b1, "R9");
    step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, "R9");
    drain("R9");
    // R10 coincident requests
    step(1'b0, 6'h23, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b0, 6'h2B, 1'b0, 1'b1, 1'b1, "R10");
    step(1'b0, 6'h23, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b0, 6'h00, 1'b1, 1'b1, 1'b0, "R10");
    step(1'b0, 6'h2B, 1'b1, 1'b0, 1'b1, "R10");
    step(1'b0, 6'h2B, 1'b1, 1'b1, 1'b1, "R10");
    drain("R10");
    // R11 reset in the middle of a full pipeline
    step(1'b0, 6'h23, 1'b0, 1'b0, 1'b0, "R11");
    step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, "R11");
    step(1'b1, 6'h2B, 1'b0, 1'b0, 1'b0, "R11");
    step(1'b0, 6'h04, 1'b0, 1'b0, 1'b0, "R11");
    drain("R11");
    // R12 exception vector
    check("R12", "excTarget", excTarget, 32'h8000_0180);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule